// File: doc/BRIEF.md
# Buck Regulator Control Register Slave (I2C)

This block is the digital control interface of a step-down regulator. It is a slave on a two-wire I2C bus and holds the regulator's run-time settings in two byte-wide registers. It turns those registers into plain control outputs: a converter-off bit, a bit that forces continuous conduction instead of pulse skipping, a 3-bit switching-frequency code and a 4-bit output-voltage code.

Both bus lines are synchronized into the system clock and pass through a glitch filter. The filter drops pulses shorter than a programmable number of clock cycles, which is 50 ns at 200 MHz by default. The slave detects START, repeated START and STOP. It acknowledges its own 7-bit device address and takes one sub-address byte, then data bytes. It drives SDA low through an open-drain enable, both for acknowledge bits and for read data.

A read transfer returns the register selected by the last sub-address written. The host has two ways to read. It can write a sub-address, issue a repeated START and then read. Or it can read directly, and the data then comes from the register picked by the previous write.

Top module: `regctl_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte 0x72 (write) and 0x73 (read), with bit 0 as the read flag. On any other address byte it gives no acknowledge. It then leaves the bus alone, and changes no register, until the next START or STOP.
- R2: A data byte written to sub-address 0x10 sets three things: convOff from bit 0, forcedCcm from bit 1, and freqSel from bits 6:4. Bits 7, 3 and 2 are ignored.
- R3: A data byte written to sub-address 0x11 sets voltCode from bits 3:0. Bits 7:4 are ignored.
- R4: Reset clears every control output to 0 and releases SDA (sdaOe = 0).
- R5: A read that follows a sub-address write and a repeated START returns the selected register MSB first. Register 0x10 reads as {0, freqSel, 00, forcedCcm, convOff}. Register 0x11 reads as {0000, voltCode}.
- R6: A read with no sub-address in its own transfer returns the register named by the most recent sub-address written.
- R7: Sub-addresses other than 0x10 and 0x11 are acknowledged. Data written to them is acknowledged but changes no output, and a read from them returns 0x00.
- R8: If the master acknowledges a read byte, the same register is sent again. If the master does not acknowledge, the slave releases SDA and drives nothing until the next START or STOP.
- R9: A pulse on SCL or SDA shorter than FILT_CYCLES clock cycles has no effect. It neither adds a bit nor creates a START or STOP.
- R10: Several data bytes in one write transfer all go to the same register, each is acknowledged, and the last one stays.
- R11: sdaOe is asserted only during an acknowledge slot the slave owns or a zero read-data bit, and it is low while no transfer addresses the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| convOff | output | 1 | Converter off when 1 |
| forcedCcm | output | 1 | Forced continuous conduction when 1, pulse skip when 0 |
| freqSel | output | 3 | Switching-frequency select code |
| voltCode | output | 4 | Output-voltage code |

## Verification
The hardest case to reach is a data-line pulse while SCL is high that is just short enough to be filtered. Unfiltered, it would look like a START or STOP in the middle of a byte. A second hard case is a clock pulse during the low phase, which would otherwise shift in an extra bit. The bench reaches both with a glitch mode in its bit-level master. In that mode every written bit carries a 4-cycle SCL pulse while the clock is low and a 4-cycle inverted SDA pulse while the clock is high. The bench then checks that the write still lands intact and is acknowledged. Reads after a master NACK and reads without a sub-address are mixed into a seeded random sequence. Random sub-addresses reach the unmapped space.

// File: rtl/regctl_pkg.sv
`timescale 1ns/1ps
package regctl_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);
  localparam int FREQ_W    = 3;
  localparam int FREQ_LSB  = 4;
  localparam int VOLT_W    = 4;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic shiftIn;
    logic latchPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_IGNORE
  } ctlState_t;
endpackage

// File: rtl/regctl_glitch_filter.sv
`timescale 1ns/1ps
module regctl_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 10,
  parameter bit RESET_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncd;
  logic [CW-1:0]          runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= {SYNC_STAGES{RESET_VAL}};
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign syncd = syncQ[SYNC_STAGES-1];

  // output follows only after FILT_CYCLES consecutive differing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleanOut <= RESET_VAL;
      runCnt   <= '0;
    end else if (syncd == cleanOut) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_CYCLES - 1)) begin
      cleanOut <= syncd;
      runCnt   <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R9: a change at the output needs the new level held at least two samples
  assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncd, 1) == cleanOut && $past(syncd, 2) == cleanOut));
endmodule

// File: rtl/regctl_ctrl.sv
`timescale 1ns/1ps
module regctl_ctrl
  import regctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclF,
  input  logic            sdaF,
  input  logic [7:0]      rxByte,
  input  logic            txBit,
  output dpStrobe_t       stb,
  output logic            sdaOe
);
  ctlState_t        state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startDet, stopDet, addrHit, byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign addrHit  = (rxByte[7:1] == DEV_ADDR);
  assign byteDone = sclFall && (bitCnt == CNT_W'(BYTE_BITS));

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    stb     = '0;
    if (startDet) begin
      stNext  = ST_ADDR;
      cntNext = '0;
    end else if (stopDet) begin
      stNext = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDAT: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end else if (byteDone) begin
            cntNext = '0;
            if (state == ST_ADDR) begin
              stNext = addrHit ? ST_ADDR_ACK : ST_IGNORE;
            end else if (state == ST_SUB) begin
              stb.latchPtr = 1'b1;
              stNext       = ST_SUB_ACK;
            end else begin
              stb.writeReg = 1'b1;
              stNext       = ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              stb.loadTx = 1'b1;
              stNext     = ST_RDAT;
            end else begin
              stNext = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDAT_ACK: begin
          if (sclFall) stNext = ST_WDAT;
        end
        ST_RDAT: begin
          if (sclRise) begin
            cntNext = bitCnt + 1'b1;
          end else if (byteDone) begin
            cntNext = '0;
            stNext  = ST_RACK;
          end else if (sclFall) begin
            stb.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise && sdaF) begin
            stNext = ST_IGNORE;
          end else if (sclFall) begin
            stb.loadTx = 1'b1;
            stNext     = ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                 (state == ST_WDAT_ACK) || ((state == ST_RDAT) && !txBit);

  // R1: a foreign address sends the slave to the ignore state
  assert_foreign_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && byteDone && !addrHit && !startDet && !stopDet) |=> (state == ST_IGNORE));
  // R8: a NACK on read data releases the line
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclRise && sdaF) |=> (state == ST_IGNORE && !sdaOe));
  // R11: no drive while no transfer addresses the slave
  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sdaOe);
  // R10: a write strobe comes only at the end of a data byte
  assert_write_slot_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |=> (state == ST_WDAT_ACK));
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN) $onehot0(stb));
endmodule

// File: rtl/regctl_regfile.sv
`timescale 1ns/1ps
module regctl_regfile
  import regctl_pkg::*;
#(
  parameter logic [7:0] SUB_CTL  = 8'h10,
  parameter logic [7:0] SUB_VOUT = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaF,
  input  dpStrobe_t         stb,
  output logic [7:0]        rxByte,
  output logic              txBit,
  output logic              convOff,
  output logic              forcedCcm,
  output logic [FREQ_W-1:0] freqSel,
  output logic [VOLT_W-1:0] voltCode
);
  logic [7:0] rxShift, txShift, ptr, readVal;

  always_comb begin
    readVal = 8'h00;
    if (ptr == SUB_CTL) begin
      readVal[0]                 = convOff;
      readVal[1]                 = forcedCcm;
      readVal[FREQ_LSB +: FREQ_W] = freqSel;
    end else if (ptr == SUB_VOUT) begin
      readVal[VOLT_W-1:0] = voltCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= SUB_CTL;
    end else begin
      if (stb.shiftIn)  rxShift <= {rxShift[6:0], sdaF};
      if (stb.latchPtr) ptr     <= rxShift;
      if (stb.loadTx)        txShift <= readVal;
      else if (stb.shiftTx)  txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convOff   <= 1'b0;
      forcedCcm <= 1'b0;
      freqSel   <= '0;
      voltCode  <= '0;
    end else if (stb.writeReg) begin
      if (ptr == SUB_CTL) begin
        convOff   <= rxShift[0];
        forcedCcm <= rxShift[1];
        freqSel   <= rxShift[FREQ_LSB +: FREQ_W];
      end else if (ptr == SUB_VOUT) begin
        voltCode <= rxShift[VOLT_W-1:0];
      end
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  // R2: control fields move only on a write strobe
  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeReg |=> $stable({convOff, forcedCcm, freqSel}));
  // R3: voltage code moves only on a write strobe
  assert_volt_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeReg |=> $stable(voltCode));
  // R6: the register pointer survives between transfers
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchPtr |=> $stable(ptr));
  // R7: unmapped sub-addresses load a zero byte for reading
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && ptr != SUB_CTL && ptr != SUB_VOUT) |=> (txShift == 8'h00));
endmodule

// File: rtl/regctl_i2c_slave.sv
`timescale 1ns/1ps
module regctl_i2c_slave
  import regctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter logic [7:0] SUB_CTL     = 8'h10,
  parameter logic [7:0] SUB_VOUT    = 8'h11,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              convOff,
  output logic              forcedCcm,
  output logic [FREQ_W-1:0] freqSel,
  output logic [VOLT_W-1:0] voltCode
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] lineRaw, lineClean;
  dpStrobe_t          stb;
  logic [7:0]         rxByte;
  logic               txBit;

  assign lineRaw = {sdaIn, sclIn};

  for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
    regctl_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES),
      .RESET_VAL  (1'b1)
    ) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (lineRaw[gi]),
      .cleanOut(lineClean[gi])
    );
  end

  regctl_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclF  (lineClean[0]),
    .sdaF  (lineClean[1]),
    .rxByte(rxByte),
    .txBit (txBit),
    .stb   (stb),
    .sdaOe (sdaOe)
  );

  regctl_regfile #(.SUB_CTL(SUB_CTL), .SUB_VOUT(SUB_VOUT)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .sdaF     (lineClean[1]),
    .stb      (stb),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .convOff  (convOff),
    .forcedCcm(forcedCcm),
    .freqSel  (freqSel),
    .voltCode (voltCode)
  );
endmodule

// File: tb/regctl_i2c_slave_test.sv
`timescale 1ns/1ps
module regctl_i2c_slave_test;
  localparam int Q = 25;             // quarter bit period in clocks
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, convOff, forcedCcm;
  logic [2:0] freqSel;
  logic [3:0] voltCode;
  logic sdaBus;
  bit glitchOn = 1'b0;
  bit done = 1'b0;

  int nChecks = 0, nFails = 0;

  // model state
  logic       mOff, mCcm;
  logic [2:0] mFreq;
  logic [3:0] mVolt;
  logic [7:0] mPtr;

  always #2.5 clk = ~clk;             // 200 MHz
  assign sdaBus = sdaM & ~sdaOe;

  regctl_i2c_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .convOff(convOff), .forcedCcm(forcedCcm), .freqSel(freqSel), .voltCode(voltCode)
  );

  function automatic logic [7:0] modelRead(input logic [7:0] sub);
    if (sub == 8'h10) return {1'b0, mFreq, 2'b00, mCcm, mOff};
    if (sub == 8'h11) return {4'h0, mVolt};
    return 8'h00;
  endfunction

  function automatic void modelWrite(input logic [7:0] sub, input logic [7:0] d);
    if (sub == 8'h10) begin
      mOff = d[0]; mCcm = d[1]; mFreq = d[6:4];
    end else if (sub == 8'h11) begin
      mVolt = d[3:0];
    end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOutputs(input string req);
    logic [10:0] act, exp;
    act = {convOff, forcedCcm, freqSel, voltCode, 2'b00};
    exp = {mOff, mCcm, mFreq, mVolt, 2'b00};
    check(act == exp, req, int'(act), int'(exp));
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic writeBit(input logic b);
    sdaM = b;
    if (glitchOn) begin
      waitQ(8); sclM = 1'b1; waitQ(4); sclM = 1'b0; waitQ(Q - 12);
    end else begin
      waitQ(Q);
    end
    sclM = 1'b1; waitQ(Q);
    if (glitchOn) begin
      sdaM = ~b; waitQ(4); sdaM = b; waitQ(Q - 4);
    end else begin
      waitQ(Q);
    end
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    b = sdaBus; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic writeByte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(a);
    acked = !a;
  endtask

  task automatic readByte(output logic [7:0] d, input bit ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    writeBit(!ackIt);
  endtask

  task automatic doWrite(input logic [7:0] sub, input logic [7:0] d, input string req);
    bit a0, a1, a2;
    busStart();
    writeByte(8'h72, a0);
    writeByte(sub, a1);
    writeByte(d, a2);
    busStop();
    modelWrite(sub, d);
    mPtr = sub;
    check(a0 && a1 && a2, {req, " write acks"}, {a0, a1, a2}, 3'b111);
    checkOutputs(req);
  endtask

  task automatic doReadSub(input logic [7:0] sub, input string req);
    bit a0, a1, a2;
    logic [7:0] v;
    busStart();
    writeByte(8'h72, a0);
    writeByte(sub, a1);
    busStart();
    writeByte(8'h73, a2);
    readByte(v, 1'b0);
    busStop();
    mPtr = sub;
    check(a0 && a1 && a2, {req, " read acks"}, {a0, a1, a2}, 3'b111);
    check(v == modelRead(sub), req, v, modelRead(sub));
  endtask

  task automatic doReadCur(input string req);
    bit a0;
    logic [7:0] v;
    busStart();
    writeByte(8'h73, a0);
    readByte(v, 1'b0);
    busStop();
    check(a0, {req, " address ack"}, a0, 1);
    check(v == modelRead(mPtr), req, v, modelRead(mPtr));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below %0d", WATCHDOG, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] v1, v2, v3;
    void'($urandom(32'h0000_5eed));
    mOff = 0; mCcm = 0; mFreq = 0; mVolt = 0; mPtr = 8'h10;

    waitQ(10);
    rstN = 1'b1;
    waitQ(5);
    // R4: reset state
    checkOutputs("R4 reset outputs");
    check(sdaOe == 1'b0, "R4 reset sdaOe", sdaOe, 0);

    // R2: control register, ignored bits set too
    doWrite(8'h10, 8'hFF, "R2 ctl all ones");
    doReadSub(8'h10, "R5 ctl readback");
    doWrite(8'h10, 8'h52, "R2 ctl pattern");
    // R3: voltage register
    doWrite(8'h11, 8'hA5, "R3 volt write");
    // R6: read without sub-address follows last write
    doReadCur("R6 current register volt");
    doWrite(8'h10, 8'h31, "R2 ctl second");
    doReadCur("R6 current register ctl");
    check(sdaOe == 1'b0, "R11 idle after transfer", sdaOe, 0);

    // R1: foreign address, following bytes ignored
    busStart();
    writeByte(8'h74, a0);
    writeByte(8'h11, a1);
    writeByte(8'h0F, a2);
    busStop();
    check(!a0, "R1 foreign address nack", a0, 0);
    check(!a1 && !a2, "R1 ignored bytes nack", {a1, a2}, 0);
    checkOutputs("R1 no change after foreign address");
    check(sdaOe == 1'b0, "R11 idle after foreign address", sdaOe, 0);

    // R7: unmapped sub-address
    doWrite(8'h20, 8'h55, "R7 unmapped write");
    doReadCur("R7 unmapped read");

    // R10: several data bytes go to one register
    busStart();
    writeByte(8'h72, a0);
    writeByte(8'h11, a1);
    writeByte(8'h03, a2);
    writeByte(8'h0C, a3);
    writeByte(8'h06, a2);
    busStop();
    modelWrite(8'h11, 8'h06); mPtr = 8'h11;
    check(a0 && a1 && a2 && a3, "R10 multi byte acks", {a0, a1, a2, a3}, 4'hF);
    checkOutputs("R10 last byte kept");

    // R8: ACK repeats register, NACK releases
    busStart();
    writeByte(8'h72, a0);
    writeByte(8'h11, a1);
    busStart();
    writeByte(8'h73, a2);
    readByte(v1, 1'b1);
    readByte(v2, 1'b0);
    readByte(v3, 1'b0);
    busStop();
    check(v1 == modelRead(8'h11) && v2 == v1, "R8 repeated byte after ack", {v1, v2}, {modelRead(8'h11), modelRead(8'h11)});
    check(v3 == 8'hFF, "R8 released after nack", v3, 8'hFF);
    check(sdaOe == 1'b0, "R8 sdaOe low after nack", sdaOe, 0);

    // R9: glitches on both lines
    glitchOn = 1'b1;
    doWrite(8'h11, 8'h09, "R9 filtered write");
    doWrite(8'h10, 8'h63, "R9 filtered ctl write");
    glitchOn = 1'b0;
    doReadSub(8'h11, "R9 readback after glitches");

    // random mix
    for (int n = 0; n < 14; n++) begin
      int op, sel;
      logic [7:0] sub, d;
      op  = $urandom % 3;
      sel = $urandom % 4;
      sub = (sel == 0 || sel == 2) ? 8'h10 : (sel == 1) ? 8'h11 : 8'($urandom);
      d   = 8'($urandom);
      case (op)
        0: doWrite(sub, d, "R2 R3 R7 random write");
        1: doReadSub(sub, "R5 R7 random read");
        default: doReadCur("R6 random current read");
      endcase
    end

    // R4: reset again clears everything
    rstN = 1'b0; waitQ(3); rstN = 1'b1; waitQ(3);
    mOff = 0; mCcm = 0; mFreq = 0; mVolt = 0; mPtr = 8'h10;
    checkOutputs("R4 second reset");

    done = 1'b1;
    finishRun();
  end
endmodule